// File: doc/BRIEF.md
# Command-List I2C Controller Sequencer

This block runs an I2C transfer in controller mode from a short list of command words that software has placed in a bank of slots. Once started it works through the slots from the first one: it issues repeated-start and stop conditions, shifts bytes out of a transmit FIFO, shifts bytes into a receive FIFO, and handles the acknowledge bit after every byte. The first transmit byte of each transfer is the 7-bit target address shifted up by one with the read/write flag in bit 0 (1 = read).

The block does not make the SCL/SDA waveforms itself. For every bus event it sends a one-cycle request to a separate bit-timing engine and waits for that engine's completion pulse, which also returns the sampled SDA level. Results come back in three ways. Each slot has a done bit. Five sticky raw flags report completion, end of list, acknowledge mismatch, arbitration loss and timeout, and each one is cleared by writing 1 to it. The two FIFO fill levels are also visible.

Top module: `i2cq_cmd_master`

## Requirements
- R1: A command word has 14 bits. [7:0] is the byte count, bit 8 enables the acknowledge check, bit 9 is the expected acknowledge (1 = NACK), bit 10 is the acknowledge the block drives after each byte of a read (1 = NACK), and [13:11] is the opcode: repeated start = 6, write = 1, read = 3, stop = 2.
- R2: A `start` pulse while idle clears every slot done bit and executes the slots in order from slot 0. `busy` is high from the next cycle until the sequence ends.
- R3: A write command pops its byte count of bytes from the TX FIFO and sends each byte MSB first. After each byte it requests one acknowledge bit with SDA released (`bit_val` = 1).
- R4: When the acknowledge check is enabled and the sampled acknowledge differs from the expected value, flag bit 2 (NACK) is set and the sequence aborts. When the check is disabled, the transfer continues whatever the target answers.
- R5: A read command requests its byte count of bytes with SDA released, assembles each byte MSB first into the RX FIFO, and drives the programmed acknowledge value after every byte.
- R6: Executing a stop command sets flag bit 0 (complete). `busy` falls on the same clock edge, and later slots are not run.
- R7: Reaching an all-zero slot, a slot with an undefined opcode, or the end of the slot bank sets flag bit 1 (end of list) and ends the sequence.
- R8: Each slot's done bit is set when that slot finishes. After an abort, the slot that was running and all later slots keep their done bits clear.
- R9: If SDA is sampled low while the block released it during a written data bit, flag bit 3 (arbitration lost) is set and no further bit requests are issued.
- R10: With a nonzero `tout_limit`, a bit request that is still unanswered more than `tout_limit` cycles after it was issued sets flag bit 4 (timeout) and aborts. A zero limit disables the timeout.
- R11: `int_raw` holds sticky flags [0] complete, [1] end of list, [2] NACK, [3] arbitration lost, [4] timeout. A 1 in `int_clr` clears the matching flag. When a flag is set and cleared in the same cycle, the set wins.
- R12: Each FIFO holds 32 bytes. A push into a full FIFO is dropped. While its reset input is high, a FIFO is empty and ignores pushes.
- R13: Bit requests are single-cycle `bit_req` pulses. `bit_op` encodes the request: 0 = start condition, 1 = stop condition, 2 = data or acknowledge bit. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Write strobe for a command slot (ignored while busy) |
| cmd_idx | input | 3 | Slot index to write |
| cmd_wdata | input | 14 | Command word |
| start | input | 1 | Pulse that starts the sequence |
| busy | output | 1 | Sequence in progress |
| slot_done | output | 8 | Per-slot done bits |
| tx_push | input | 1 | Push a byte into the TX FIFO |
| tx_data | input | 8 | Byte to push |
| tx_level | output | 6 | TX FIFO fill level |
| rx_pop | input | 1 | Pop the RX FIFO head |
| rx_data | output | 8 | RX FIFO head byte |
| rx_level | output | 6 | RX FIFO fill level |
| tx_fifo_rst | input | 1 | Hold-to-empty reset of the TX FIFO |
| rx_fifo_rst | input | 1 | Hold-to-empty reset of the RX FIFO |
| tout_limit | input | 16 | Timeout limit in cycles, 0 = off |
| int_clr | input | 5 | Write-one-to-clear for the flags |
| int_raw | output | 5 | Sticky raw flags |
| bit_req | output | 1 | Request pulse to the bit-timing engine |
| bit_op | output | 2 | Requested bus event |
| bit_val | output | 1 | SDA level to present (1 = released) |
| bit_done | input | 1 | Engine completion pulse |
| bit_rx | input | 1 | SDA level sampled by the engine |

## Verification
The collision case is a completion flag being set while software is clearing it. A stop command finishes on the same edge that `busy` falls. The bench holds the write-one-to-clear bit for the complete flag high for the whole transfer. At the first sample where `busy` is low, the flag must read 1, because the set takes priority over the clear. At the next sample it must read 0, because the clear is still applied. A bus-level scoreboard checks every written byte and every acknowledge the controller drives, comparing them against the expected sequence while the target model answers.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

   localparam int FLAG_N = 5;
   localparam int FL_CMPL = 0;
   localparam int FL_END  = 1;
   localparam int FL_NACK = 2;
   localparam int FL_ARB  = 3;
   localparam int FL_TOUT = 4;

   localparam logic [2:0] OP_RSTART = 3'd6;
   localparam logic [2:0] OP_WRITE  = 3'd1;
   localparam logic [2:0] OP_READ   = 3'd3;
   localparam logic [2:0] OP_STOP   = 3'd2;

   localparam logic [1:0] BOP_START = 2'd0;
   localparam logic [1:0] BOP_STOP  = 2'd1;
   localparam logic [1:0] BOP_BIT   = 2'd2;

   typedef struct packed {
      logic [2:0] op;
      logic       ack_val;
      logic       ack_exp;
      logic       chk;
      logic [7:0] cnt;
   } cmd_word_t;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_LOAD, S_REQ, S_WAIT
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_START, PH_STOP, PH_DATA, PH_ACK
   } seq_phase_t;

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
   parameter int DEPTH = 32,
   parameter int W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       empty,
   output logic                       full
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNTW = $clog2(DEPTH+1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("i2cq_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("i2cq_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == CNTW'(DEPTH));
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign rdata   = mem[rd_ptr];

   if ((1 << AW) == DEPTH) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNTW'(DEPTH));
   a_r12_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
   a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/i2cq_cmd_store.sv
module i2cq_cmd_store
   import i2cq_pkg::*;
#(
   parameter int NSLOT = 8,
   parameter int IDXW  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDXW-1:0]  wr_idx,
   input  logic [13:0]      wr_word,
   input  logic             busy,
   input  logic             go,
   input  logic [IDXW:0]    rd_idx,
   output cmd_word_t        rd_word,
   input  logic             done_set,
   output logic [NSLOT-1:0] slot_done
);
   if (NSLOT < 1 || NSLOT > (1 << IDXW)) begin : g_bad_slots
      $error("i2cq_cmd_store: NSLOT does not fit IDXW");
   end

   logic [13:0] slot_q [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[s]    <= '0;
            slot_done[s] <= 1'b0;
         end else begin
            if (wr_en && !busy && (wr_idx == IDXW'(s)))
               slot_q[s] <= wr_word;
            if (go)
               slot_done[s] <= 1'b0;
            else if (done_set && (rd_idx == (IDXW+1)'(s)))
               slot_done[s] <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_word = '0;
      if (rd_idx < (IDXW+1)'(NSLOT))
         rd_word = cmd_word_t'(slot_q[rd_idx[IDXW-1:0]]);
   end

   a_r2_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (slot_done == '0));
   a_r8_done_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go) |=> $stable(slot_done));

endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
   import i2cq_pkg::*;
#(
   parameter int NSLOT = 8,
   parameter int IDXW  = 3,
   parameter int TOUTW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  cmd_word_t         word,
   output logic [IDXW:0]     idx,
   output logic              busy,
   output logic              done_set,
   input  logic              tx_empty,
   input  logic [7:0]        tx_rdata,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [7:0]        rx_wdata,
   output logic              bit_req,
   output logic [1:0]        bit_op,
   output logic              bit_val,
   input  logic              bit_done,
   input  logic              bit_rx,
   input  logic [TOUTW-1:0]  tout_limit,
   output logic [FLAG_N-1:0] flag_set
);
   if (TOUTW < 1) begin : g_bad_tout
      $error("i2cq_seq: TOUTW must be positive");
   end

   seq_state_t        state;
   seq_phase_t        phase;
   logic [7:0]        shreg;
   logic [7:0]        left;
   logic [2:0]        bitn;
   logic              is_rd;
   logic [TOUTW-1:0]  tcnt;

   logic wait_done, known_op, xfer_op, zero_len;
   logic nack_hit, arb_hit, tout_hit, end_hit, cmpl_hit, last_ack;

   assign known_op  = (word.op == OP_RSTART) || (word.op == OP_STOP) ||
                      (word.op == OP_WRITE)  || (word.op == OP_READ);
   assign xfer_op   = (word.op == OP_WRITE) || (word.op == OP_READ);
   assign zero_len  = (state == S_FETCH) && xfer_op && (word.cnt == 8'd0);
   assign wait_done = (state == S_WAIT) && bit_done;
   assign nack_hit  = wait_done && (phase == PH_ACK) && !is_rd && word.chk &&
                      (bit_rx != word.ack_exp);
   assign arb_hit   = wait_done && (phase == PH_DATA) && !is_rd && shreg[7] && !bit_rx;
   assign tout_hit  = (state == S_WAIT) && !bit_done && (tout_limit != '0) &&
                      (tcnt == tout_limit);
   assign end_hit   = (state == S_FETCH) && !known_op;
   assign cmpl_hit  = wait_done && (phase == PH_STOP);
   assign last_ack  = wait_done && (phase == PH_ACK) && !nack_hit && (left == 8'd1);

   assign done_set  = (wait_done && (phase == PH_START)) || cmpl_hit || last_ack || zero_len;

   always_comb begin
      flag_set          = '0;
      flag_set[FL_CMPL] = cmpl_hit;
      flag_set[FL_END]  = end_hit;
      flag_set[FL_NACK] = nack_hit;
      flag_set[FL_ARB]  = arb_hit;
      flag_set[FL_TOUT] = tout_hit;
   end

   assign busy     = (state != S_IDLE);
   assign tx_pop   = (state == S_LOAD) && !tx_empty;
   assign rx_push  = wait_done && (phase == PH_ACK) && is_rd;
   assign rx_wdata = shreg;
   assign bit_req  = (state == S_REQ);

   always_comb begin
      bit_op  = BOP_BIT;
      bit_val = 1'b1;
      case (phase)
         PH_START: bit_op = BOP_START;
         PH_STOP:  bit_op = BOP_STOP;
         PH_DATA:  bit_val = is_rd ? 1'b1 : shreg[7];
         PH_ACK:   bit_val = is_rd ? word.ack_val : 1'b1;
         default:  bit_op = BOP_BIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         phase <= PH_START;
         shreg <= '0;
         left  <= '0;
         bitn  <= '0;
         is_rd <= 1'b0;
         tcnt  <= '0;
         idx   <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (go) begin
                  idx   <= '0;
                  state <= S_FETCH;
               end
            end
            S_FETCH: begin
               case (word.op)
                  OP_RSTART: begin phase <= PH_START; state <= S_REQ; end
                  OP_STOP:   begin phase <= PH_STOP;  state <= S_REQ; end
                  OP_WRITE, OP_READ: begin
                     is_rd <= (word.op == OP_READ);
                     left  <= word.cnt;
                     if (word.cnt == 8'd0) begin
                        idx <= idx + 1'b1;
                     end else if (word.op == OP_READ) begin
                        bitn  <= '0;
                        phase <= PH_DATA;
                        state <= S_REQ;
                     end else begin
                        state <= S_LOAD;
                     end
                  end
                  default: state <= S_IDLE;
               endcase
            end
            S_LOAD: begin
               shreg <= tx_empty ? 8'hFF : tx_rdata;
               bitn  <= '0;
               phase <= PH_DATA;
               state <= S_REQ;
            end
            S_REQ: begin
               tcnt  <= '0;
               state <= S_WAIT;
            end
            S_WAIT: begin
               if (bit_done) begin
                  case (phase)
                     PH_START: begin idx <= idx + 1'b1; state <= S_FETCH; end
                     PH_STOP:  state <= S_IDLE;
                     PH_DATA: begin
                        if (arb_hit) begin
                           state <= S_IDLE;
                        end else begin
                           shreg <= {shreg[6:0], bit_rx};
                           bitn  <= bitn + 1'b1;
                           if (bitn == 3'd7) phase <= PH_ACK;
                           state <= S_REQ;
                        end
                     end
                     default: begin
                        if (nack_hit) begin
                           state <= S_IDLE;
                        end else if (left == 8'd1) begin
                           idx   <= idx + 1'b1;
                           state <= S_FETCH;
                        end else begin
                           left <= left - 1'b1;
                           if (is_rd) begin
                              bitn  <= '0;
                              phase <= PH_DATA;
                              state <= S_REQ;
                           end else begin
                              state <= S_LOAD;
                           end
                        end
                     end
                  endcase
               end else if (tout_hit) begin
                  state <= S_IDLE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   a_r13_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req |=> !bit_req);
   a_r10_tout_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_WAIT) && (tout_limit != '0)) |-> (tcnt <= tout_limit));
   a_r3_write_pop_only_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LOAD) |=> (state == S_REQ) && (phase == PH_DATA));
   a_r7_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= (IDXW+1)'(NSLOT));

endmodule

// File: rtl/i2cq_cmd_master.sv
module i2cq_cmd_master
   import i2cq_pkg::*;
#(
   parameter int NSLOT      = 8,
   parameter int FIFO_DEPTH = 32,
   parameter int TOUTW      = 16,
   localparam int IDXW      = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int LVLW      = $clog2(FIFO_DEPTH+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [IDXW-1:0]   cmd_idx,
   input  logic [13:0]       cmd_wdata,
   input  logic              start,
   output logic              busy,
   output logic [NSLOT-1:0]  slot_done,
   input  logic              tx_push,
   input  logic [7:0]        tx_data,
   output logic [LVLW-1:0]   tx_level,
   input  logic              rx_pop,
   output logic [7:0]        rx_data,
   output logic [LVLW-1:0]   rx_level,
   input  logic              tx_fifo_rst,
   input  logic              rx_fifo_rst,
   input  logic [TOUTW-1:0]  tout_limit,
   input  logic [FLAG_N-1:0] int_clr,
   output logic [FLAG_N-1:0] int_raw,
   output logic              bit_req,
   output logic [1:0]        bit_op,
   output logic              bit_val,
   input  logic              bit_done,
   input  logic              bit_rx
);
   logic              go;
   logic [IDXW:0]     idx;
   cmd_word_t         word;
   logic              done_set;
   logic              tx_pop, tx_empty, tx_full;
   logic [7:0]        tx_rdata;
   logic              rx_push, rx_empty, rx_full;
   logic [7:0]        rx_wdata;
   logic [FLAG_N-1:0] flag_set;

   assign go = start && !busy;

   i2cq_cmd_store #(.NSLOT(NSLOT), .IDXW(IDXW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(cmd_we), .wr_idx(cmd_idx), .wr_word(cmd_wdata),
      .busy(busy), .go(go), .rd_idx(idx), .rd_word(word), .done_set(done_set),
      .slot_done(slot_done));

   i2cq_seq #(.NSLOT(NSLOT), .IDXW(IDXW), .TOUTW(TOUTW)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .word(word), .idx(idx), .busy(busy),
      .done_set(done_set), .tx_empty(tx_empty), .tx_rdata(tx_rdata), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .bit_req(bit_req), .bit_op(bit_op),
      .bit_val(bit_val), .bit_done(bit_done), .bit_rx(bit_rx), .tout_limit(tout_limit),
      .flag_set(flag_set));

   i2cq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_fifo_rst), .push(tx_push), .wdata(tx_data),
      .pop(tx_pop), .rdata(tx_rdata), .level(tx_level), .empty(tx_empty), .full(tx_full));

   i2cq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_fifo_rst), .push(rx_push), .wdata(rx_wdata),
      .pop(rx_pop), .rdata(rx_data), .level(rx_level), .empty(rx_empty), .full(rx_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_raw <= '0;
      else        int_raw <= (int_raw & ~int_clr) | flag_set;
   end

   a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set != '0) |=> ((int_raw & $past(flag_set)) == $past(flag_set)));
   a_r6_complete_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_raw[FL_CMPL]) |-> !busy);
   a_r9_arb_stops_requests: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_raw[FL_ARB]) |-> (!busy && !bit_req));
   a_r13_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bit_req);

endmodule

// File: tb/i2cq_cmd_master_test.sv
module i2cq_cmd_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [2:0]  cmd_idx = '0;
   logic [13:0] cmd_wdata = '0;
   logic        start = 1'b0;
   logic        busy;
   logic [7:0]  slot_done;
   logic        tx_push = 1'b0;
   logic [7:0]  tx_data = '0;
   logic [5:0]  tx_level;
   logic        rx_pop = 1'b0;
   logic [7:0]  rx_data;
   logic [5:0]  rx_level;
   logic        tx_fifo_rst = 1'b0;
   logic        rx_fifo_rst = 1'b0;
   logic [15:0] tout_limit = 16'd50;
   logic [4:0]  int_clr = '0;
   logic [4:0]  int_raw;
   logic        bit_req;
   logic [1:0]  bit_op;
   logic        bit_val;
   logic        bit_done = 1'b0;
   logic        bit_rx = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;

   // target model controls
   int lat = 2;
   bit stall = 1'b0;
   int nack_at = -1;
   int arb_byte = -1;
   int arb_bit = -1;
   int reqs = 0;
   logic [7:0] exp_bus[$];
   logic       exp_ack[$];
   logic [7:0] slave_q[$];

   always #2 clk = ~clk;

   i2cq_cmd_master uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
      .start(start), .busy(busy), .slot_done(slot_done), .tx_push(tx_push), .tx_data(tx_data),
      .tx_level(tx_level), .rx_pop(rx_pop), .rx_data(rx_data), .rx_level(rx_level),
      .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst), .tout_limit(tout_limit),
      .int_clr(int_clr), .int_raw(int_raw), .bit_req(bit_req), .bit_op(bit_op),
      .bit_val(bit_val), .bit_done(bit_done), .bit_rx(bit_rx));

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   function automatic logic [13:0] mk(input logic [2:0] op, input logic [7:0] cnt,
                                      input logic ck, input logic ex, input logic av);
      return {op, av, ex, ck, cnt};
   endfunction

   // target and bit-engine model; scoreboard monitor for bus bytes
   initial begin
      int bitn = 0, byte_no = 0;
      logic rw = 1'b0;
      logic [7:0] rcv = '0, scur = '0;
      forever begin
         @(negedge clk);
         bit_done = 1'b0;
         if (bit_req) begin
            logic [1:0] op;
            logic v, rx, mw;
            reqs++;
            op = bit_op;
            v  = bit_val;
            rx = 1'b1;
            if (!stall) begin
               mw = (byte_no == 0) || !rw;
               if (op == 2'd0) begin
                  bitn = 0; byte_no = 0; rx = 1'b1;
               end else if (op == 2'd1) begin
                  bitn = 0; rx = 1'b1;
               end else if (bitn < 8) begin
                  if (mw) begin
                     rx  = v & !((arb_byte == byte_no) && (arb_bit == bitn));
                     rcv = {rcv[6:0], v};
                  end else begin
                     if (bitn == 0) scur = (slave_q.size() > 0) ? slave_q.pop_front() : 8'hFF;
                     rx = v & scur[7-bitn];
                  end
                  bitn++;
               end else begin
                  if (mw) begin
                     logic [7:0] e;
                     rx = (byte_no == nack_at) ? 1'b1 : 1'b0;
                     if (byte_no == 0) rw = rcv[0];
                     e = (exp_bus.size() > 0) ? exp_bus.pop_front() : 8'hXX;
                     chk(rcv === e, "R3 written byte", rcv, e);
                  end else begin
                     logic ea;
                     ea = (exp_ack.size() > 0) ? exp_ack.pop_front() : 1'bx;
                     chk(v === ea, "R5 driven read ack", v, ea);
                     rx = v;
                  end
                  bitn = 0;
                  byte_no++;
               end
               repeat (lat) @(negedge clk);
               bit_rx   = rx;
               bit_done = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic set_slot(input int i, input logic [13:0] w);
      @(negedge clk);
      cmd_we = 1'b1; cmd_idx = 3'(i); cmd_wdata = w;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic clear_slots();
      for (int i = 0; i < 8; i++) set_slot(i, 14'h0);
   endtask

   task automatic push_tx(input logic [7:0] b);
      @(negedge clk);
      tx_push = 1'b1; tx_data = b;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   // ends at the first negedge where busy is low
   task automatic run();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic clear_flags();
      int_clr = 5'h1F;
      @(negedge clk);
      int_clr = 5'h00;
      @(negedge clk);
   endtask

   task automatic drain_tx();
      tx_fifo_rst = 1'b1;
      @(negedge clk);
      tx_fifo_rst = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(busy == 1'b0 && bit_req == 1'b0, "R2 idle after reset", busy, 0);
      chk(int_raw == 5'h00, "R11 flags clear after reset", int_raw, 0);
      chk(slot_done == 8'h00, "R8 done bits clear after reset", slot_done, 0);
      chk(tx_level == 0 && rx_level == 0, "R12 fifos empty after reset", tx_level, 0);

      // write transfer, complete flag set while its clear bit is held
      set_slot(0, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      set_slot(1, mk(3'd1, 8'd3, 1'b1, 1'b0, 1'b0));
      set_slot(2, mk(3'd2, 8'd0, 1'b0, 1'b0, 1'b0));
      push_tx(8'hA0); push_tx(8'hA5); push_tx(8'h3C);
      exp_bus.push_back(8'hA0); exp_bus.push_back(8'hA5); exp_bus.push_back(8'h3C);
      int_clr = 5'b00001;
      run();
      chk(int_raw[0] == 1'b1, "R11 set wins over clear", int_raw, 5'h01);
      chk(int_raw[1] == 1'b0, "R6 stop ends before end-of-list", int_raw, 5'h01);
      @(negedge clk);
      chk(int_raw[0] == 1'b0, "R11 held clear removes flag", int_raw, 0);
      int_clr = 5'b00000;
      chk(slot_done == 8'h07, "R8 done bits after write", slot_done, 8'h07);
      chk(exp_bus.size() == 0, "R3 all bytes sent", exp_bus.size(), 0);
      chk(tx_level == 0, "R3 tx fifo drained", tx_level, 0);
      clear_flags();

      // read transfer: R1 field decoding and R5 ack values
      clear_slots();
      set_slot(0, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      set_slot(1, mk(3'd1, 8'd1, 1'b1, 1'b0, 1'b0));
      set_slot(2, mk(3'd3, 8'd2, 1'b0, 1'b0, 1'b0));
      set_slot(3, mk(3'd3, 8'd1, 1'b0, 1'b0, 1'b1));
      set_slot(4, mk(3'd2, 8'd0, 1'b0, 1'b0, 1'b0));
      push_tx(8'hA1);
      exp_bus.push_back(8'hA1);
      slave_q.push_back(8'h11); slave_q.push_back(8'h22); slave_q.push_back(8'h3C);
      exp_ack.push_back(1'b0); exp_ack.push_back(1'b0); exp_ack.push_back(1'b1);
      run();
      chk(int_raw == 5'h01, "R5 read completes without arbitration flag", int_raw, 5'h01);
      chk(slot_done == 8'h1F, "R1 R8 done bits after read", slot_done, 8'h1F);
      chk(rx_level == 6'd3, "R5 rx level", rx_level, 3);
      chk(exp_ack.size() == 0, "R5 all acks driven", exp_ack.size(), 0);
      begin
         logic [7:0] want [3] = '{8'h11, 8'h22, 8'h3C};
         for (int i = 0; i < 3; i++) begin
            chk(rx_data == want[i], "R5 read byte", rx_data, want[i]);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
         end
      end
      clear_flags();

      // target NACKs the second byte with check enabled
      clear_slots();
      set_slot(0, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      set_slot(1, mk(3'd1, 8'd3, 1'b1, 1'b0, 1'b0));
      set_slot(2, mk(3'd2, 8'd0, 1'b0, 1'b0, 1'b0));
      push_tx(8'hA0); push_tx(8'h01); push_tx(8'h02);
      exp_bus.push_back(8'hA0); exp_bus.push_back(8'h01);
      nack_at = 1;
      run();
      chk(int_raw == 5'h04, "R4 nack flag and abort", int_raw, 5'h04);
      chk(slot_done == 8'h01, "R8 incomplete slots stay clear", slot_done, 8'h01);
      chk(tx_level == 6'd1, "R4 remaining byte not sent", tx_level, 1);
      drain_tx();
      clear_flags();

      // same with check disabled: transfer completes
      set_slot(1, mk(3'd1, 8'd3, 1'b0, 1'b0, 1'b0));
      push_tx(8'hA0); push_tx(8'h01); push_tx(8'h02);
      exp_bus.push_back(8'hA0); exp_bus.push_back(8'h01); exp_bus.push_back(8'h02);
      run();
      nack_at = -1;
      chk(int_raw == 5'h01, "R4 check disabled ignores nack", int_raw, 5'h01);
      chk(slot_done == 8'h07, "R4 all slots done", slot_done, 8'h07);
      clear_flags();

      // expected NACK but target ACKs
      set_slot(1, mk(3'd1, 8'd1, 1'b1, 1'b1, 1'b0));
      push_tx(8'hA0);
      exp_bus.push_back(8'hA0);
      run();
      chk(int_raw == 5'h04, "R4 ack differs from expected nack", int_raw, 5'h04);
      clear_flags();

      // empty slot ends the list
      clear_slots();
      set_slot(0, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      set_slot(1, mk(3'd1, 8'd1, 1'b1, 1'b0, 1'b0));
      push_tx(8'hA0);
      exp_bus.push_back(8'hA0);
      run();
      chk(int_raw == 5'h02, "R7 empty slot end-of-list", int_raw, 5'h02);
      chk(slot_done == 8'h03, "R7 done bits before empty slot", slot_done, 8'h03);
      clear_flags();

      // undefined opcode ends the list
      set_slot(1, mk(3'd5, 8'd1, 1'b0, 1'b0, 1'b0));
      run();
      chk(int_raw == 5'h02, "R7 undefined opcode end-of-list", int_raw, 5'h02);
      chk(slot_done == 8'h01, "R7 undefined slot not done", slot_done, 8'h01);
      clear_flags();

      // running off the end of the bank
      for (int i = 0; i < 8; i++) set_slot(i, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      reqs = 0;
      run();
      chk(int_raw == 5'h02, "R7 past last slot end-of-list", int_raw, 5'h02);
      chk(slot_done == 8'hFF, "R2 slots run in order", slot_done, 8'hFF);
      chk(reqs == 8, "R13 one request per start", reqs, 8);
      clear_flags();

      // arbitration loss on the first address bit
      clear_slots();
      set_slot(0, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      set_slot(1, mk(3'd1, 8'd1, 1'b1, 1'b0, 1'b0));
      set_slot(2, mk(3'd2, 8'd0, 1'b0, 1'b0, 1'b0));
      push_tx(8'hA0);
      arb_byte = 0; arb_bit = 0; reqs = 0;
      run();
      repeat (10) @(negedge clk);
      chk(int_raw == 5'h08, "R9 arbitration flag", int_raw, 5'h08);
      chk(reqs == 2, "R9 no requests after loss", reqs, 2);
      chk(slot_done == 8'h01, "R9 done bits after loss", slot_done, 8'h01);
      arb_byte = -1; arb_bit = -1;
      clear_flags();

      // timeout with a stalled engine
      clear_slots();
      set_slot(0, mk(3'd6, 8'd0, 1'b0, 1'b0, 1'b0));
      set_slot(1, mk(3'd2, 8'd0, 1'b0, 1'b0, 1'b0));
      tout_limit = 16'd20; stall = 1'b1;
      run();
      chk(int_raw == 5'h10, "R10 timeout flag", int_raw, 5'h10);
      chk(slot_done == 8'h00, "R10 no slot done after timeout", slot_done, 0);
      stall = 1'b0;
      clear_flags();

      // zero limit disables timeout even with a slow engine
      tout_limit = 16'd0; lat = 30;
      run();
      chk(int_raw == 5'h01, "R10 zero limit disables timeout", int_raw, 5'h01);
      lat = 2; tout_limit = 16'd50;
      clear_flags();

      // FIFO capacity and reset
      for (int i = 0; i < 33; i++) push_tx(8'(i));
      chk(tx_level == 6'd32, "R12 push into full fifo dropped", tx_level, 32);
      tx_fifo_rst = 1'b1;
      tx_push = 1'b1; tx_data = 8'h55;
      @(negedge clk);
      @(negedge clk);
      tx_push = 1'b0;
      chk(tx_level == 6'd0, "R12 reset empties and ignores pushes", tx_level, 0);
      tx_fifo_rst = 1'b0;
      @(negedge clk);
      chk(tx_level == 6'd0, "R12 fifo stays empty after reset", tx_level, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule